// File: doc/BRIEF.md
# Flash Status Pin Mode Controller

This block drives the status pin of a flash memory device. After reset the pin gives a ready/busy level: it is low while the internal write state machine works and high otherwise, suspended included. Software can instead make the pin an interrupt source. In that case it gives a low pulse of fixed length when a program operation completes, when an erase operation completes, or in both cases. Between pulses it stays high, whatever the busy flag does.

A mode change takes two writes on the command bus: a configuration opcode and then a code byte. The opcode is taken only while the device is idle and not suspended. A rejected opcode, a code byte with any reserved bit set, or the retired read-configuration opcode sets both sequence-error bits of the status register. A clear-status strobe clears both bits again. Only the pin logic and these two error bits are modelled.

Top module: `flash_sts_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the mode is level, both error outputs are 0 and the sequencer is waiting for an opcode.
- R2: In level mode sts_o equals the inverse of wsm_busy_i, combinationally. Suspended with busy low reads as high.
- R3: A mode change is an opcode write of CFG_OPC (default 0xB8) followed by a code write. The new mode applies to completion events from the cycle after the code write. Other data written while waiting for an opcode is ignored.
- R4: Code bit 0 enables pulses on erase_done_i and code bit 1 enables pulses on prog_done_i. A completion event whose type is disabled leaves sts_o high.
- R5: In a pulse mode, an enabled event sampled at a clock edge drives sts_o low for exactly PULSE_CYC cycles starting at that edge. The default of 50 cycles is 250 ns at 200 MHz.
- R6: In a pulse mode, sts_o is high whenever no pulse is running, regardless of wsm_busy_i.
- R7: An enabled event that arrives during a pulse restarts the full PULSE_CYC count.
- R8: Code 0x00 restores level mode.
- R9: If the opcode arrives while wsm_busy_i or suspended_i is high, it is rejected: both error bits are set, no code byte is expected, and the mode does not change.
- R10: A code byte with any of bits 7..2 set is rejected: both error bits are set and the mode does not change.
- R11: A write of LEGACY_OPC (default 0x60) while waiting for an opcode sets both error bits.
- R12: clr_status_i clears both error bits. If an error is raised in the same cycle, the error wins.
- R13: The mode is held until the next accepted code byte or until rst_ni goes low, which returns the pin to level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | One-cycle command write strobe |
| cmd_data_i | input | 8 | Command or code byte |
| clr_status_i | input | 1 | Clear both error bits |
| wsm_busy_i | input | 1 | Write state machine busy |
| suspended_i | input | 1 | Program or erase suspended |
| prog_done_i | input | 1 | One-cycle program completion event |
| erase_done_i | input | 1 | One-cycle erase completion event |
| sts_o | output | 1 | Status pin, level or pulse |
| sr_err4_o | output | 1 | Status bit 4, sequence error |
| sr_err5_o | output | 1 | Status bit 5, sequence error |

## Verification
The bench rejects the opcode once while suspended and once while busy, then writes a code-like byte. A design that still took the code would leave level mode, and the busy flag would no longer pull the pin low.

It measures the pulse length edge by edge and sends a second erase event in the middle of a pulse. An off-by-one counter gives the wrong length, and a counter that does not restart would raise the pin two cycles early.

It sends completion events of the disabled type, sends events of both types together, and raises busy while in a pulse mode. These catch swapped enable bits and busy leaking into pulse mode.

It sends a clear in the same cycle as the retired opcode, where the error must win. It also pulls reset while in a pulse mode, which must bring level mode back.

// File: rtl/flash_sts_pkg.sv
`timescale 1ns/1ps
package flash_sts_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CODE = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic prog_en;
    logic erase_en;
  } sts_cfg_t;

  localparam sts_cfg_t CFG_LEVEL = '{prog_en: 1'b0, erase_en: 1'b0};
endpackage

// File: rtl/fsc_cmd_seq.sv
`timescale 1ns/1ps
module fsc_cmd_seq
  import flash_sts_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_OPC    = 8'hB8,
  parameter logic [BYTE_W-1:0] LEGACY_OPC = 8'h60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic              clr_status_i,
  input  logic              wsm_busy_i,
  input  logic              suspended_i,
  output sts_cfg_t          cfg_o,
  output logic              cfg_wr_o,
  output logic              err_o,
  output seq_state_e        state_o
);
  localparam int unsigned CODE_BITS = $bits(sts_cfg_t);

  seq_state_e state_q, state_d;
  sts_cfg_t   cfg_q;
  logic       err_q, err_d;
  logic       is_cfg_op, is_legacy_op, rsvd_set, dev_blocked;
  logic       set_err;

  assign is_cfg_op    = (cmd_data_i == CFG_OPC);
  assign is_legacy_op = (cmd_data_i == LEGACY_OPC);
  assign rsvd_set     = |cmd_data_i[BYTE_W-1:CODE_BITS];
  assign dev_blocked  = wsm_busy_i | suspended_i;

  always_comb begin
    state_d  = state_q;
    set_err  = 1'b0;
    cfg_wr_o = 1'b0;
    if (cmd_we_i) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (is_cfg_op) begin
            if (dev_blocked) set_err = 1'b1;
            else             state_d = SEQ_CODE;
          end else if (is_legacy_op) begin
            set_err = 1'b1;
          end
        end
        SEQ_CODE: begin
          state_d = SEQ_IDLE;
          if (rsvd_set) set_err  = 1'b1;
          else          cfg_wr_o = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  // error raise has priority over clear
  always_comb begin
    err_d = err_q;
    if (set_err)           err_d = 1'b1;
    else if (clr_status_i) err_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cfg_q   <= CFG_LEVEL;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (cfg_wr_o) cfg_q <= sts_cfg_t'(cmd_data_i[CODE_BITS-1:0]);
    end
  end

  assign cfg_o   = cfg_q;
  assign err_o   = err_q;
  assign state_o = state_q;
endmodule

// File: rtl/fsc_pulse_gen.sv
`timescale 1ns/1ps
module fsc_pulse_gen
  import flash_sts_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sts_cfg_t cfg_i,
  input  logic     cfg_wr_i,
  input  logic     prog_done_i,
  input  logic     erase_done_i,
  output logic     pulse_o
);
  localparam int unsigned CNT_W = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             trig;

  assign trig = (erase_done_i & cfg_i.erase_en) | (prog_done_i & cfg_i.prog_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cfg_wr_i)        cnt_q <= '0;
    else if (trig)            cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/fsc_pin_mux.sv
`timescale 1ns/1ps
module fsc_pin_mux
  import flash_sts_pkg::*;
(
  input  sts_cfg_t cfg_i,
  input  logic     wsm_busy_i,
  input  logic     pulse_i,
  output logic     sts_o
);
  logic level_mode;
  assign level_mode = (cfg_i == CFG_LEVEL);
  assign sts_o = level_mode ? ~wsm_busy_i : ~pulse_i;
endmodule

// File: rtl/flash_sts_ctrl.sv
`timescale 1ns/1ps
module flash_sts_ctrl
  import flash_sts_pkg::*;
#(
  parameter logic [7:0]  CFG_OPC    = 8'hB8,
  parameter logic [7:0]  LEGACY_OPC = 8'h60,
  parameter int unsigned PULSE_CYC  = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_data_i,
  input  logic       clr_status_i,
  input  logic       wsm_busy_i,
  input  logic       suspended_i,
  input  logic       prog_done_i,
  input  logic       erase_done_i,
  output logic       sts_o,
  output logic       sr_err4_o,
  output logic       sr_err5_o
);
  sts_cfg_t   cfg;
  logic       cfg_wr;
  logic       seq_err;
  logic       pulse;
  seq_state_e seq_state;

  fsc_cmd_seq #(.CFG_OPC(CFG_OPC), .LEGACY_OPC(LEGACY_OPC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we_i),
    .cmd_data_i   (cmd_data_i),
    .clr_status_i (clr_status_i),
    .wsm_busy_i   (wsm_busy_i),
    .suspended_i  (suspended_i),
    .cfg_o        (cfg),
    .cfg_wr_o     (cfg_wr),
    .err_o        (seq_err),
    .state_o      (seq_state)
  );

  fsc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .cfg_wr_i     (cfg_wr),
    .prog_done_i  (prog_done_i),
    .erase_done_i (erase_done_i),
    .pulse_o      (pulse)
  );

  fsc_pin_mux u_mux (
    .cfg_i      (cfg),
    .wsm_busy_i (wsm_busy_i),
    .pulse_i    (pulse),
    .sts_o      (sts_o)
  );

  // both sequence-error bits report the same condition
  assign sr_err4_o = seq_err;
  assign sr_err5_o = seq_err;
endmodule

// File: rtl/fsc_sts_chk.sv
`timescale 1ns/1ps
module fsc_sts_chk
  import flash_sts_pkg::*;
#(
  parameter logic [7:0] CFG_OPC    = 8'hB8,
  parameter logic [7:0] LEGACY_OPC = 8'h60
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [7:0] cmd_data_i,
  input logic       clr_status_i,
  input logic       wsm_busy_i,
  input logic       suspended_i,
  input logic       prog_done_i,
  input logic       erase_done_i,
  input logic       sts_o,
  input logic       sr_err4_o,
  input logic       sr_err5_o,
  input sts_cfg_t   cfg,
  input seq_state_e seq_state
);
  a_r2_level_tracks_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg == CFG_LEVEL) |-> (sts_o == !wsm_busy_i));

  a_r6_pulse_fall_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg != CFG_LEVEL) && $stable(cfg) && $fell(sts_o)) |->
      $past((erase_done_i & cfg.erase_en) | (prog_done_i & cfg.prog_en)));

  a_r9_blocked_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && seq_state == SEQ_IDLE && cmd_data_i == CFG_OPC && (wsm_busy_i || suspended_i))
      |=> (sr_err4_o && sr_err5_o && $stable(cfg) && seq_state == SEQ_IDLE));

  a_r10_reserved_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && seq_state == SEQ_CODE && (|cmd_data_i[7:2]))
      |=> (sr_err4_o && sr_err5_o && $stable(cfg)));

  a_r11_legacy_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && seq_state == SEQ_IDLE && cmd_data_i == LEGACY_OPC) |=> (sr_err4_o && sr_err5_o));

  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && !cmd_we_i) |=> (!sr_err4_o && !sr_err5_o));

  a_r13_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_we_i && seq_state == SEQ_CODE) |=> $stable(cfg));
endmodule

bind flash_sts_ctrl fsc_sts_chk #(.CFG_OPC(CFG_OPC), .LEGACY_OPC(LEGACY_OPC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_data_i   (cmd_data_i),
  .clr_status_i (clr_status_i),
  .wsm_busy_i   (wsm_busy_i),
  .suspended_i  (suspended_i),
  .prog_done_i  (prog_done_i),
  .erase_done_i (erase_done_i),
  .sts_o        (sts_o),
  .sr_err4_o    (sr_err4_o),
  .sr_err5_o    (sr_err5_o),
  .cfg          (cfg),
  .seq_state    (seq_state)
);

// File: tb/sim_flash_sts_ctrl.sv
`timescale 1ns/1ps
module sim_flash_sts_ctrl;
  localparam int unsigned PULSE = 4;
  localparam int unsigned NVEC  = 51;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_we_i = 1'b0;
  logic [7:0] cmd_data_i = 8'h00;
  logic       clr_status_i = 1'b0;
  logic       wsm_busy_i = 1'b0;
  logic       suspended_i = 1'b0;
  logic       prog_done_i = 1'b0;
  logic       erase_done_i = 1'b0;
  logic       sts_o, sr_err4_o, sr_err5_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  flash_sts_ctrl #(.PULSE_CYC(PULSE)) u0 (.*);

  // {req[27:24], data[23:16], ctl{we,busy,susp,clr}[15:12], ev{-,-,prog,erase}[11:8], exp{sts[4],err[0]}[7:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    28'h1_00_0_0_10, // R1 idle
    28'h2_00_4_0_00, // R2 busy low
    28'h2_00_2_0_10, // R2 suspended high
    28'h9_B8_A_0_11, // R9 opcode while suspended
    28'hC_00_1_0_10, // R12 clear
    28'h9_B8_C_0_01, // R9 opcode while busy
    28'h9_01_8_0_11, // R9 no code expected
    28'h9_00_4_1_01, // R9 still level
    28'hC_00_1_0_10,
    28'h3_B8_8_0_10, // R3 opcode
    28'hA_05_8_0_11, // R10 reserved bit
    28'hA_00_4_0_01, // R10 still level
    28'hC_00_1_0_10,
    28'hB_60_8_0_11, // R11 legacy
    28'hC_00_1_0_10,
    28'h3_B8_8_0_10,
    28'h3_01_8_0_10, // R3 erase mode
    28'h6_00_4_0_10, // R6 busy ignored
    28'h4_00_0_2_10, // R4 program disabled
    28'h5_00_0_1_00, // R5 pulse starts
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_10, // R5 ends after PULSE
    28'h7_00_0_1_00,
    28'h7_00_0_0_00,
    28'h7_00_0_1_00, // R7 retrigger
    28'h7_00_0_0_00,
    28'h7_00_0_0_00,
    28'h7_00_0_0_00,
    28'h7_00_0_0_10,
    28'h3_B8_8_0_10,
    28'h3_02_8_0_10, // R3 program mode
    28'h4_00_0_1_10, // R4 erase disabled
    28'h4_00_0_2_00, // R4 program pulse
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_10,
    28'h3_B8_8_0_10,
    28'h3_03_8_0_10, // R4 both
    28'h4_00_0_3_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_00,
    28'h5_00_0_0_10,
    28'h3_B8_8_0_10,
    28'h8_00_8_0_10, // R8 back to level
    28'h8_00_4_0_00,
    28'hC_60_9_0_11, // R12 set wins over clear
    28'hC_00_1_0_10
  };

  task automatic check(input int req, input logic exp_sts, input logic exp_err);
    checks++;
    if (sts_o !== exp_sts || sr_err4_o !== exp_err || sr_err5_o !== exp_err) begin
      errors++;
      $display("FAIL R%0d: sts=%b err4=%b err5=%b expected sts=%b err=%b",
               req, sts_o, sr_err4_o, sr_err5_o, exp_sts, exp_err);
    end
  endtask

  task automatic drive(input logic [27:0] v);
    cmd_data_i   = v[23:16];
    cmd_we_i     = v[15];
    wsm_busy_i   = v[14];
    suspended_i  = v[13];
    clr_status_i = v[12];
    prog_done_i  = v[9];
    erase_done_i = v[8];
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, 1'b1, 1'b0);          // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 1'b1, 1'b0);          // R1 after release
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      @(negedge clk_i);
      check(int'(VEC[i][27:24]), VEC[i][4], VEC[i][0]);
    end
    // R13: pulse mode held, then reset restores level
    drive(28'hD_B8_8_0_10); @(negedge clk_i);
    drive(28'hD_01_8_0_10); @(negedge clk_i);
    drive(28'hD_00_4_0_10); @(negedge clk_i);
    check(13, 1'b1, 1'b0);
    repeat (5) @(negedge clk_i);
    check(13, 1'b1, 1'b0);
    rst_ni = 1'b0;
    #1;
    check(13, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(13, 1'b0, 1'b0);
    drive(28'hD_00_0_0_10);
    @(negedge clk_i);
    check(13, 1'b1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule